// File: doc/BRIEF.md
# Vertical Compression Scaler for Picture-in-Picture

This block shrinks a 4:2:2 YCbCr active-video stream in the vertical direction by a whole-number factor so that it can be shown as an inset picture. It receives the samples of each line as one multiplexed luma/chroma stream. A line-valid strobe marks the samples of a line, and a one-cycle field-start strobe marks the top of every field. The block adds up each group of N consecutive lines, sample position by sample position, in a line-wide accumulator. On the last line of the group it emits the rounded mean of those N lines, one output sample for each input sample.

The factor N can be 1, 2, 3, 4 or 6. It is read from a select input only at field start, so a field is never scaled with two different factors. With N equal to 1 the stream passes straight through with the same latency as every other mode. For the even factors, averaging an even number of lines cancels the line-alternating chroma phase of the source. The block then raises a request that an external chroma delay-line stage be bypassed.

Top module: `vscl_pip_vcomp`

## Requirements
- R1: The select input codes map to the factor N as follows: 0 gives 1, 1 gives 2, 2 gives 3, 3 gives 4, 4 gives 6, and 5 to 7 give 1. The select input is sampled only in a cycle where field_start is high. Changes at other times have no effect, and after reset N is 1.
- R2: With N = 1, every accepted input sample appears unchanged on data_out, with out_valid high, in the cycle after it is presented.
- R3: With N > 1, output is produced only while the last line of each group of N lines arrives. The sample at position i of that line yields, one cycle later, out_valid high and data_out = floor((S + floor(N/2)) / N), where S is the sum of position i over the N lines of the group.
- R4: Lines that are not the last of their group produce no out_valid. Whenever out_valid is low, data_out is 0.
- R5: A field_start pulse resets the line-group count to the start of a group. The lines of a group left unfinished at that point are discarded and contribute nothing to later outputs.
- R6: A line ends in the first cycle with line_valid low after a cycle with line_valid high. When a line end and field_start fall in the same cycle, the field start takes priority and the next line begins a new group.
- R7: bypass_req is high exactly when the latched factor is 2, 4 or 6. It changes only in the cycle after a field_start pulse.
- R8: Within a line, samples at positions LINE_MAX and beyond (counting from 0) are ignored. They produce no output and do not enter the accumulator.
- R9: During and right after reset, out_valid, data_out and bypass_req are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| field_start | input | 1 | One-cycle pulse at the top of a field, given while line_valid is low |
| line_valid | input | 1 | High for each sample of an active line |
| ratio_sel | input | 3 | Compression factor code, see R1 |
| data_in | input | DATA_W | Multiplexed Y/Cb/Y/Cr sample |
| out_valid | output | 1 | High for each emitted output sample |
| data_out | output | DATA_W | Averaged sample, 0 when out_valid is low |
| bypass_req | output | 1 | Request to bypass the external chroma delay line |

## Verification
The two events that can land in the same cycle are a line end and a field start. The bench provokes this by raising field_start in the cycle directly after the last sample of a line, with N = 2 and one line already accumulated. An arithmetic model of the group count judges the result: the line after the field start must begin a fresh group, so no output may appear until the second line that follows. A further sweep covers every select code, partial groups cut off by a field start, full-scale sums, and lines longer than the accumulator.

// File: rtl/vscl_pkg.sv
// Shared types and helper functions for the vertical compression scaler.
// Assumes: the factor code is 3 bits wide. Unused codes fall back to pass-through.
package vscl_pkg;

    localparam int RATIO_W = 3;

    typedef logic [RATIO_W-1:0] ratio_t;

    // Map a select code to the compression factor N.
    function automatic ratio_t decode_ratio(input logic [2:0] sel);
        case (sel)
            3'd1:    return 3'd2;
            3'd2:    return 3'd3;
            3'd3:    return 3'd4;
            3'd4:    return 3'd6;
            default: return 3'd1;
        endcase
    endfunction

    // Even factors average out the line-alternating chroma phase.
    function automatic logic is_even_ratio(input ratio_t n);
        return (n == 3'd2) || (n == 3'd4) || (n == 3'd6);
    endfunction

endpackage

// File: rtl/vscl_line_ctl.sv
// Line and group sequencing for the vertical compression scaler.
// Tracks the sample position within a line, the line phase within a
// group of N lines, and latches N and the bypass request at field start.
// Assumes: field_start arrives while line_valid is low.
module vscl_line_ctl
    import vscl_pkg::*;
#(
    parameter int LINE_MAX = 1440,
    parameter int IDX_W    = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             field_start,
    input  logic             line_valid,
    input  logic [2:0]       ratio_sel,
    output ratio_t           ratio_n,
    output ratio_t           phase,
    output logic [IDX_W-1:0] idx,
    output logic             sample_ok,
    output logic             first_line,
    output logic             last_line,
    output logic             bypass_req
);

    localparam logic [IDX_W-1:0] IDX_LIM = IDX_W'(LINE_MAX);

    logic lv_q;
    logic line_end;

    assign line_end   = lv_q && !line_valid;
    assign sample_ok  = line_valid && (idx != IDX_LIM);
    assign first_line = (phase == '0);
    assign last_line  = (phase == ratio_t'(ratio_n - 3'd1));

    // Sample position counter: counts inside a line, saturates at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                idx <= '0;
        else if (!line_valid)      idx <= '0;
        else if (idx != IDX_LIM)   idx <= idx + 1'b1;
    end

    // Delayed line-valid, used to find the end of a line.
    always_ff @(posedge clk) begin
        if (!rst_n) lv_q <= 1'b0;
        else        lv_q <= line_valid;
    end

    // Line phase within a group; a field start overrides a line end.
    always_ff @(posedge clk) begin
        if (!rst_n)           phase <= '0;
        else if (field_start) phase <= '0;
        else if (line_end)    phase <= last_line ? '0 : ratio_t'(phase + 3'd1);
    end

    // Factor and bypass request, latched only at field start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_n    <= 3'd1;
            bypass_req <= 1'b0;
        end else if (field_start) begin
            ratio_n    <= decode_ratio(ratio_sel);
            bypass_req <= is_even_ratio(decode_ratio(ratio_sel));
        end
    end

endmodule

// File: rtl/vscl_line_acc.sv
// Line-wide accumulator for the vertical compression scaler.
// Holds one partial sum per sample position. The first line of a group
// starts a fresh sum, and the last line is not written back.
// Assumes: the memory needs no reset, because every read is preceded by a
// write from the first line of the same group.
module vscl_line_acc #(
    parameter int DATA_W   = 8,
    parameter int ACC_W    = 11,
    parameter int LINE_MAX = 1440,
    parameter int AW       = 11
) (
    input  logic              clk,
    input  logic [AW-1:0]     addr,
    input  logic              sample_ok,
    input  logic              first_line,
    input  logic              last_line,
    input  logic [DATA_W-1:0] data_in,
    output logic [ACC_W-1:0]  sum_now
);

    logic [ACC_W-1:0] mem [LINE_MAX];
    logic [ACC_W-1:0] prior;

    // Select the running sum, or zero at the start of a group.
    always_comb begin
        if (first_line || !sample_ok) prior = '0;
        else                          prior = mem[addr];
        sum_now = prior + ACC_W'(data_in);
    end

    // Store the updated partial sum for all but the last line of a group.
    always_ff @(posedge clk) begin
        if (sample_ok && !last_line) mem[addr] <= sum_now;
    end

endmodule

// File: rtl/vscl_round_div.sv
// Rounded division of a line sum by the factor N (1, 2, 3, 4 or 6).
// Powers of two use an add-and-shift. Factors 3 and 6 use a fixed
// reciprocal multiply, with enough fraction bits that the result equals
// floor((S + floor(N/2)) / N) for every sum that fits in ACC_W bits.
module vscl_round_div
    import vscl_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ACC_W  = 11
) (
    input  logic [ACC_W-1:0]  sum,
    input  ratio_t            ratio_n,
    output logic [DATA_W-1:0] q
);

    localparam int SH = ACC_W + 5;
    localparam int PW = ACC_W + SH + 1;
    localparam logic [PW-1:0] ONE   = PW'(1);
    localparam logic [PW-1:0] K3    = ((ONE << SH) + PW'(2)) / PW'(3);
    localparam logic [PW-1:0] K6    = ((ONE << SH) + PW'(5)) / PW'(6);
    localparam logic [PW-1:0] Q_MAX = PW'({DATA_W{1'b1}});

    logic [PW-1:0] sx;
    logic [PW-1:0] q_full;

    assign sx = PW'(sum);

    // Quotient selection by factor.
    always_comb begin
        case (ratio_n)
            3'd2:    q_full = (sx + PW'(1)) >> 1;
            3'd3:    q_full = ((sx + PW'(1)) * K3) >> SH;
            3'd4:    q_full = (sx + PW'(2)) >> 2;
            3'd6:    q_full = ((sx + PW'(3)) * K6) >> SH;
            default: q_full = sx;
        endcase
    end

    // Clamp to the sample range; the mean never exceeds it.
    assign q = (q_full > Q_MAX) ? {DATA_W{1'b1}} : q_full[DATA_W-1:0];

endmodule

// File: rtl/vscl_pip_vcomp.sv
// Top of the vertical compression scaler for inset pictures.
// Averages groups of N lines of a multiplexed 4:2:2 stream into one line.
// One register stage sits between the input and the output in every mode.
// Assumes: lines are at most LINE_MAX samples long; longer tails are dropped.
module vscl_pip_vcomp
    import vscl_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int LINE_MAX = 1440
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_start,
    input  logic              line_valid,
    input  logic [2:0]        ratio_sel,
    input  logic [DATA_W-1:0] data_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] data_out,
    output logic              bypass_req
);

    localparam int ACC_W = DATA_W + 3;
    localparam int IDX_W = $clog2(LINE_MAX + 1);
    localparam int AW    = (LINE_MAX > 1) ? $clog2(LINE_MAX) : 1;

    ratio_t            ratio_n;
    ratio_t            phase;
    logic [IDX_W-1:0]  idx;
    logic              sample_ok;
    logic              first_line;
    logic              last_line;
    logic [ACC_W-1:0]  sum_now;
    logic [DATA_W-1:0] mean;
    logic              emit;

    vscl_line_ctl #(
        .LINE_MAX (LINE_MAX),
        .IDX_W    (IDX_W)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .field_start(field_start),
        .line_valid (line_valid),
        .ratio_sel  (ratio_sel),
        .ratio_n    (ratio_n),
        .phase      (phase),
        .idx        (idx),
        .sample_ok  (sample_ok),
        .first_line (first_line),
        .last_line  (last_line),
        .bypass_req (bypass_req)
    );

    vscl_line_acc #(
        .DATA_W  (DATA_W),
        .ACC_W   (ACC_W),
        .LINE_MAX(LINE_MAX),
        .AW      (AW)
    ) u_acc (
        .clk       (clk),
        .addr      (idx[AW-1:0]),
        .sample_ok (sample_ok),
        .first_line(first_line),
        .last_line (last_line),
        .data_in   (data_in),
        .sum_now   (sum_now)
    );

    vscl_round_div #(
        .DATA_W(DATA_W),
        .ACC_W (ACC_W)
    ) u_div (
        .sum    (sum_now),
        .ratio_n(ratio_n),
        .q      (mean)
    );

    assign emit = sample_ok && last_line;

    // Output register: emitted means, zero data otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            data_out  <= '0;
        end else begin
            out_valid <= emit;
            data_out  <= emit ? mean : '0;
        end
    end

endmodule

// File: rtl/vscl_pip_vcomp_chk.sv
// Property checker for the vertical compression scaler, attached by bind.
// Observes the ports together with the sequencer's factor, phase and position.
module vscl_pip_vcomp_chk
    import vscl_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int LINE_MAX = 1440,
    parameter int IDX_W    = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              field_start,
    input logic              line_valid,
    input logic [DATA_W-1:0] data_in,
    input logic              out_valid,
    input logic [DATA_W-1:0] data_out,
    input logic              bypass_req,
    input ratio_t            ratio_n,
    input ratio_t            phase,
    input logic [IDX_W-1:0]  idx
);

    localparam logic [IDX_W-1:0] IDX_LIM = IDX_W'(LINE_MAX);

    // R2
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_n == 3'd1 && line_valid && idx < IDX_LIM)
            |=> (out_valid && data_out == $past(data_in)));

    // R3
    out_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(line_valid));

    // R4
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (data_out == '0));

    // R5
    group_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |=> (phase == '0));

    // R7
    bypass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !field_start |=> $stable(bypass_req));

    // R8
    tail_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && idx >= IDX_LIM) |=> !out_valid);

endmodule

bind vscl_pip_vcomp vscl_pip_vcomp_chk #(
    .DATA_W  (DATA_W),
    .LINE_MAX(LINE_MAX),
    .IDX_W   (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .field_start(field_start),
    .line_valid (line_valid),
    .data_in    (data_in),
    .out_valid  (out_valid),
    .data_out   (data_out),
    .bypass_req (bypass_req),
    .ratio_n    (ratio_n),
    .phase      (phase),
    .idx        (idx)
);

// File: tb/sim_vscl_pip_vcomp.sv
// Self-checking bench: sweeps every factor code over short lines, with an
// arithmetic model of grouping, rounding and the bypass request.
module sim_vscl_pip_vcomp;

    localparam int DW  = 8;
    localparam int LMX = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          field_start = 1'b0;
    logic          line_valid = 1'b0;
    logic [2:0]    ratio_sel = 3'd0;
    logic [DW-1:0] data_in = '0;
    logic          out_valid;
    logic [DW-1:0] data_out;
    logic          bypass_req;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    string cur_req = "R3";

    int m_n     = 1;
    int m_phase = 0;
    int m_idx   = 0;
    bit m_prev  = 1'b0;
    bit m_byp   = 1'b0;
    int m_sum [LMX];

    always #5 clk = ~clk;

    vscl_pip_vcomp #(.DATA_W(DW), .LINE_MAX(LMX)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .field_start(field_start),
        .line_valid (line_valid),
        .ratio_sel  (ratio_sel),
        .data_in    (data_in),
        .out_valid  (out_valid),
        .data_out   (data_out),
        .bypass_req (bypass_req)
    );

    function automatic int factor_of(input int code);
        if (code == 1) return 2;
        if (code == 2) return 3;
        if (code == 3) return 4;
        if (code == 4) return 6;
        return 1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive inputs, advance the model, then compare after the edge.
    task automatic step(input bit lv, input bit fs, input int d);
        bit    ev;
        int    ed;
        int    s;
        string tag;
        line_valid  = lv;
        field_start = fs;
        data_in     = d[DW-1:0];
        ev = 1'b0;
        ed = 0;
        if (fs) begin
            m_n     = factor_of(int'(ratio_sel));
            m_phase = 0;
            m_byp   = (m_n == 2) || (m_n == 4) || (m_n == 6);
        end else if (m_prev && !lv) begin
            m_phase = (m_phase == m_n - 1) ? 0 : m_phase + 1;
        end
        if (lv && m_idx < LMX) begin
            s = ((m_phase == 0) ? 0 : m_sum[m_idx]) + d;
            if (m_phase == m_n - 1) begin
                ev = 1'b1;
                ed = (s + m_n / 2) / m_n;
            end else begin
                m_sum[m_idx] = s;
            end
        end
        if (lv) begin
            if (m_idx < LMX) m_idx++;
        end else begin
            m_idx = 0;
        end
        m_prev = lv;
        @(negedge clk);
        if (ev) tag = cur_req;
        else    tag = (cur_req == "R2" || cur_req == "R3") ? "R4" : cur_req;
        check(out_valid === ev, tag, int'(out_valid), int'(ev));
        check(data_out === ed[DW-1:0], tag, int'(data_out), ed);
        check(bypass_req === m_byp, "R7", int'(bypass_req), int'(m_byp));
    endtask

    task automatic new_field(input int code);
        ratio_sel = code[2:0];
        step(1'b0, 1'b1, 0);
        step(1'b0, 1'b0, 0);
    endtask

    // One line of len samples; seed 0 gives full-scale samples.
    task automatic send_line(input int len, input int ln, input int seed);
        for (int i = 0; i < len; i++)
            step(1'b1, 1'b0, (seed == 0) ? 255 : ((ln * 53 + i * 29 + seed * 17) % 256));
        step(1'b0, 1'b0, 0);
        step(1'b0, 1'b0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check(out_valid === 1'b0, "R9", int'(out_valid), 0);
        check(data_out === '0, "R9", int'(data_out), 0);
        check(bypass_req === 1'b0, "R9", int'(bypass_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0 && bypass_req === 1'b0, "R9", int'(out_valid), 0);

        // R2/R3/R1: every select code, 13 lines each (partial tails included)
        for (int code = 0; code < 8; code++) begin
            cur_req = (factor_of(code) == 1) ? "R2" : "R3";
            if (code > 4) cur_req = "R1";
            new_field(code);
            for (int ln = 0; ln < 13; ln++) send_line(12, ln, code + 1);
        end

        // R3: full-scale sums for every factor
        cur_req = "R3";
        for (int code = 1; code < 5; code++) begin
            new_field(code);
            for (int ln = 0; ln < 6; ln++) send_line(LMX, ln, 0);
        end

        // R5: a partial group is dropped at field start
        cur_req = "R5";
        new_field(3);
        for (int ln = 0; ln < 6; ln++) send_line(10, ln, 40);
        new_field(3);
        for (int ln = 0; ln < 4; ln++) send_line(10, ln, 41);

        // R6: field start in the very cycle of a line end
        cur_req = "R6";
        new_field(1);
        for (int i = 0; i < 12; i++) step(1'b1, 1'b0, 200 - i);
        ratio_sel = 3'd1;
        step(1'b0, 1'b1, 0);
        step(1'b0, 1'b0, 0);
        for (int ln = 0; ln < 4; ln++) send_line(12, ln, 7);

        // R1: select changes without field start are ignored
        cur_req = "R1";
        new_field(1);
        ratio_sel = 3'd4;
        for (int ln = 0; ln < 4; ln++) send_line(12, ln, 9);
        ratio_sel = 3'd0;
        for (int ln = 0; ln < 2; ln++) send_line(12, ln, 11);

        // R8: samples past the line capacity are ignored
        cur_req = "R8";
        new_field(0);
        send_line(LMX + 5, 0, 13);
        new_field(1);
        for (int ln = 0; ln < 4; ln++) send_line(LMX + 6, ln, 21);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0 (timeout)");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule